// File: doc/BRIEF.md
# Byte-Wide Additive Stream Whitener

This block whitens an outgoing bit stream, or restores an incoming one, by XORing every data bit with the running output of a 7-bit linear feedback shift register. One byte is taken per clock. The eight register steps that a byte needs are unrolled into combinational logic, so the block keeps up with a full-rate byte stream.

Scrambling and descrambling are the same operation. A receiver loads the same seed that the transmitter used and passes the whitened bytes through. Result bytes appear one clock after they are accepted. The register state carries over from one byte to the next until a new seed is loaded. A seed can be loaded at any time through its own port.

Top module: `byte_whitener`

## Requirements
- R1: While reset is asserted and just after it is released, `out_valid` is 0 and `out_data` is 0. The register state after reset is the `SEED` parameter, which defaults to all ones.
- R2: Each single step computes a feedback bit as state bit 3 XOR state bit 0. State bits 6..1 then move into positions 5..0, and the feedback bit goes into bit 6. The output bit is the input bit XOR that feedback bit.
- R3: Within a byte, bit 0 is handled by the first step and bit 7 by the eighth step. The state advances by exactly eight steps for each accepted byte.
- R4: When `in_valid` is 1 on a rising edge, `out_valid` is 1 after that edge and `out_data` holds the scrambled byte. When `in_valid` is 0, `out_valid` is 0 after that edge.
- R5: A cycle with `in_valid` at 0 and `seed_load` at 0 leaves the register state and `out_data` unchanged.
- R6: When `seed_load` is 1, the next state is `seed_val`, and this takes priority over the data step. A byte accepted in that same cycle is scrambled with the old state. The first byte accepted after the load uses the new seed.
- R7: Scrambling a sequence, loading the same seed again and passing the result back through returns the original bytes.
- R8: An all-zero state yields a zero mask, so bytes pass through unchanged and the state stays all zero.
- R9: With any nonzero seed and the default taps, the mask sequence repeats every 127 bits. Zero input bytes k and k+127 therefore give equal outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| seed_load | input | 1 | Load `seed_val` into the register state |
| seed_val | input | STATE_W | Seed value to load |
| in_valid | input | 1 | Input byte is present |
| in_data | input | LANES | Input byte, bit 0 is processed first |
| out_valid | output | 1 | Output byte is present |
| out_data | output | LANES | Scrambled byte |

## Verification
The bench builds the block with its default parameters: a 7-bit state, 8 lanes, taps at bits 3 and 0, and an all-ones reset seed. With these taps the feedback polynomial is maximal-length, which makes the 127-bit period visible as a byte repeat after 127 bytes. Every other starting state, including the all-zero lock-up state, is reached through the seed port. The bench does not need other parameter builds for these cases.

// File: rtl/whit_pkg.sv
package whit_pkg;
    // Next-state action chosen each cycle
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_STEP = 2'd1,
        ACT_LOAD = 2'd2
    } whit_act_e;
endpackage

// File: rtl/whit_step.sv
module whit_step #(
    parameter int W      = 7,
    parameter int TAP_HI = 3,
    parameter int TAP_LO = 0
) (
    input  logic [W-1:0] cur,
    output logic [W-1:0] nxt,
    output logic         fb
);
    // One register step: the feedback enters at the top, the rest shifts down
    assign fb  = cur[TAP_HI] ^ cur[TAP_LO];
    assign nxt = {fb, cur[W-1:1]};
endmodule

// File: rtl/whit_unroll.sv
module whit_unroll #(
    parameter int W      = 7,
    parameter int LANES  = 8,
    parameter int TAP_HI = 3,
    parameter int TAP_LO = 0
) (
    input  logic [W-1:0]     start,
    output logic [LANES-1:0] mask,
    output logic [W-1:0]     fin
);
    logic [W-1:0] chain [0:LANES];

    assign chain[0] = start;

    // Lane g handles data bit g, so bit 0 sees the first step
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        whit_step #(.W(W), .TAP_HI(TAP_HI), .TAP_LO(TAP_LO)) u_step (
            .cur (chain[g]),
            .nxt (chain[g+1]),
            .fb  (mask[g])
        );
    end

    assign fin = chain[LANES];
endmodule

// File: rtl/byte_whitener.sv
module byte_whitener #(
    parameter int                  STATE_W = 7,
    parameter int                  LANES   = 8,
    parameter int                  TAP_HI  = 3,
    parameter int                  TAP_LO  = 0,
    parameter logic [STATE_W-1:0]  SEED    = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               seed_load,
    input  logic [STATE_W-1:0] seed_val,
    input  logic               in_valid,
    input  logic [LANES-1:0]   in_data,
    output logic               out_valid,
    output logic [LANES-1:0]   out_data
);
    import whit_pkg::*;

    typedef struct packed {
        logic [STATE_W-1:0] state;
        logic               vld;
        logic [LANES-1:0]   data;
    } whit_regs_t;

    whit_regs_t         r_d, r_q;
    logic [LANES-1:0]   mask;
    logic [STATE_W-1:0] adv_state;
    logic [STATE_W-1:0] state_q;
    whit_act_e          act;

    whit_unroll #(
        .W      (STATE_W),
        .LANES  (LANES),
        .TAP_HI (TAP_HI),
        .TAP_LO (TAP_LO)
    ) u_unroll (
        .start (r_q.state),
        .mask  (mask),
        .fin   (adv_state)
    );

    // A seed load takes priority over the data step
    always_comb begin
        if (seed_load)     act = ACT_LOAD;
        else if (in_valid) act = ACT_STEP;
        else               act = ACT_HOLD;
    end

    always_comb begin
        r_d     = r_q;
        r_d.vld = in_valid;
        if (in_valid) begin
            r_d.data = in_data ^ mask;
        end
        case (act)
            ACT_LOAD: r_d.state = seed_val;
            ACT_STEP: r_d.state = adv_state;
            default:  r_d.state = r_q.state;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: SEED, vld: 1'b0, data: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign state_q   = r_q.state;
    assign out_valid = r_q.vld;
    assign out_data  = r_q.data;
endmodule

// File: rtl/whit_checker.sv
module whit_checker #(
    parameter int STATE_W = 7,
    parameter int LANES   = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               seed_load,
    input logic [STATE_W-1:0] seed_val,
    input logic               in_valid,
    input logic [LANES-1:0]   in_data,
    input logic               out_valid,
    input logic [LANES-1:0]   out_data,
    input logic [STATE_W-1:0] state_q
);
    p_valid_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data));

    p_state_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !seed_load) |=> $stable(state_q));

    p_seed_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
        seed_load |=> (state_q == $past(seed_val)));

    p_zero_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && state_q == '0) |=> (out_data == $past(in_data)));

    p_zero_stay_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == '0 && !seed_load) |=> (state_q == '0));
endmodule

bind byte_whitener whit_checker #(.STATE_W(STATE_W), .LANES(LANES)) u_whit_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .seed_load (seed_load),
    .seed_val  (seed_val),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data),
    .state_q   (state_q)
);

// File: tb/test_byte_whitener.sv
module test_byte_whitener;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       seed_load = 1'b0;
    logic [6:0] seed_val = '0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       out_valid;
    logic [7:0] out_data;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic [7:0] cap_q [$];
    logic [6:0] m_state = 7'h7F;
    string      cur_req = "R1";
    logic [7:0] last_out = '0;
    bit         have_last = 0;

    always #5 clk = ~clk;

    byte_whitener i_byte_whitener (
        .clk       (clk),
        .rst_n     (rst_n),
        .seed_load (seed_load),
        .seed_val  (seed_val),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    // Bit-serial reference of the register
    function automatic logic [7:0] ref_scramble(input logic [7:0] d, inout logic [6:0] s);
        logic [7:0] o;
        logic       fb;
        for (int i = 0; i < 8; i++) begin
            fb   = s[3] ^ s[0];
            o[i] = d[i] ^ fb;
            s    = {fb, s[6:1]};
        end
        return o;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic drive(input logic [7:0] d, input bit ld, input logic [6:0] sd,
                         input bit vld, input bit force_exp, input logic [7:0] fexp);
        logic [6:0] tmp;
        logic [7:0] e;
        @(negedge clk);
        in_valid  = vld;
        in_data   = d;
        seed_load = ld;
        seed_val  = sd;
        tmp = m_state;
        e = ref_scramble(d, tmp);
        if (vld) begin
            exp_q.push_back(force_exp ? fexp : e);
            tag_q.push_back(cur_req);
        end
        if (ld)       m_state = sd;
        else if (vld) m_state = tmp;
    endtask

    task automatic send(input logic [7:0] d);
        drive(d, 0, '0, 1, 0, '0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive('0, 0, '0, 0, 0, '0);
    endtask

    task automatic load(input logic [6:0] sd);
        drive('0, 1, sd, 0, 0, '0);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R4: actual=unexpected output %h expected=none", out_data);
                end else begin
                    check(tag_q.pop_front(), out_data, exp_q.pop_front());
                end
                cap_q.push_back(out_data);
                last_out  = out_data;
                have_last = 1;
            end else if (have_last) begin
                check("R5", out_data, last_out);
            end
        end
    end

    task automatic finish_up();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_up();
    end

    initial begin
        logic [7:0] orig [10];
        logic [7:0] scr [10];
        logic [7:0] per [$];

        // R1: reset values at the ports
        repeat (3) @(negedge clk);
        check("R1", {7'd0, out_valid}, 8'd0);
        check("R1", out_data, 8'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {7'd0, out_valid}, 8'd0);

        // R1: first byte uses the reset seed
        cur_req = "R1"; send(8'h00);
        // R2: step rule over several patterns
        cur_req = "R2"; send(8'h00); send(8'hFF); send(8'hA5); send(8'h3C);
        // R3: single-bit inputs exercise lane order
        cur_req = "R3"; send(8'h01); send(8'h80); send(8'h10);
        // R4: back-to-back stream
        cur_req = "R4";
        for (int i = 0; i < 16; i++) send(8'(i * 37 + 5));
        // R5: gaps leave the state alone
        cur_req = "R5";
        send(8'h55); idle(3); send(8'h55); idle(1); send(8'h0F);
        // R6: load with no data, then with data in the same cycle
        cur_req = "R6";
        load(7'h15); send(8'h00); send(8'h99);
        drive(8'h77, 1, 7'h2A, 1, 0, '0);
        send(8'h00); send(8'hC4);
        // R8: all-zero state passes data unchanged
        cur_req = "R8";
        load(7'h00);
        drive(8'h5A, 0, '0, 1, 1, 8'h5A);
        drive(8'hC3, 0, '0, 1, 1, 8'hC3);
        idle(2);
        drive(8'hE1, 0, '0, 1, 1, 8'hE1);
        idle(2);

        // R9: period of 127 bits shows as a 127-byte repeat
        cur_req = "R9";
        load(7'h7F);
        idle(1);
        cap_q.delete();
        for (int i = 0; i < 130; i++) send(8'h00);
        idle(2);
        for (int i = 0; i < 130; i++) per.push_back(cap_q[i]);
        for (int k = 0; k < 3; k++) check("R9", per[k + 127], per[k]);

        // R7: scramble, reload same seed, scramble again
        cur_req = "R7";
        load(7'h5B);
        idle(1);
        cap_q.delete();
        for (int i = 0; i < 10; i++) begin
            orig[i] = 8'(i * 29 + 3);
            send(orig[i]);
        end
        idle(2);
        for (int i = 0; i < 10; i++) scr[i] = cap_q[i];
        load(7'h5B);
        for (int i = 0; i < 10; i++) drive(scr[i], 0, '0, 1, 1, orig[i]);
        idle(3);

        // R4: every accepted byte produced an output
        check("R4", 8'(exp_q.size()), 8'd0);
        finish_up();
    end
endmodule